// File: doc/BRIEF.md
# Zero-Suppressed Hit Packet Builder

This block turns one front-end chip's digitized samples into a compact serial packet each time a level-1 trigger is accepted. It walks the chip's 128 six-bit channel samples, which a readout buffer holds stable, and compares each one against a programmable threshold. A channel whose sample is above the threshold becomes a hit, and only hits are written out. The packet is therefore as long as the occupancy requires rather than a fixed dump of every channel.

Each packet opens with the chip identifier and the orbit-counter value captured when the trigger arrived. A 13-bit record follows for each hit, holding the channel number and then the pulse height. A short all-ones terminator closes the packet. The output runs at one bit per clock, framed by a valid strobe.

Triggers that arrive while a packet is still going out wait in a small queue. If the queue is full, the trigger is lost and a sticky error flag is raised.

Top module: `zs_packet_builder`

## Requirements
- R1: Every accepted trigger yields exactly one packet. With the block idle and the queue empty, a trigger sampled at clock edge k puts the first packet bit on `ser_data`, with `ser_valid` high, in the cycle after edge k+1.
- R2: The packet begins with the 8-bit `chip_id`, then the 12-bit `orbit` value sampled at the edge that accepted the trigger. Both fields are sent most significant bit first.
- R3: A channel produces a record only when its sample is strictly greater than `thr`. A sample equal to or below `thr` produces nothing. Each record is the 7-bit channel number followed by the 6-bit sample, both most significant bit first.
- R4: Records appear in ascending channel order.
- R5: Channel 127 never produces a record, whatever its sample.
- R6: After the last record comes a 7-bit terminator of all ones. With n records, the packet is 27 + 13·n bits long. The header and records alone take 20 + 13·n bits, which is 85 bits at n = 5.
- R7: `ser_valid` stays high without a break for the whole packet. Between two packets it is low for at least one cycle, and for exactly one cycle when a trigger is already waiting.
- R8: Triggers that arrive during a packet are queued, up to 4 deep. They are served in arrival order, and each packet carries its own trigger's timestamp.
- R9: A trigger that finds the queue full, with no entry leaving in that same cycle, is dropped and produces no packet. `ovf_err` then goes high and stays high until reset.
- R10: During and right after reset, `ser_valid` and `ovf_err` are low and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Level-1 trigger strobe, one cycle per trigger |
| samples | input | 768 | 128 samples of 6 bits; channel c occupies bits [6c+5:6c] |
| thr | input | 6 | Hit threshold |
| chip_id | input | 8 | Fixed chip identifier |
| orbit | input | 12 | Running orbit counter |
| ser_data | output | 1 | Serial packet bit |
| ser_valid | output | 1 | High while a packet bit is on `ser_data` |
| ovf_err | output | 1 | Sticky trigger-queue overflow flag |

## Verification
A trigger is taken in at its sampling edge. The first header bit follows one cycle later, and every later bit follows its predecessor by exactly one cycle, so a packet with n records ends 27 + 13·n cycles after it starts. Queued packets are spaced by exactly one idle cycle. The bench drives inputs and samples outputs on falling edges. It checks the start cycle against that two-edge latency and rebuilds every packet bit by bit from the sample array, the threshold and the orbit value captured at the trigger's falling edge. It also measures the idle gap between back-to-back packets and reads the overflow flag at the edge just before, and the edge just after, the dropped trigger.

// File: rtl/zs_pkg.sv
package zs_pkg;
  parameter int unsigned N_CH   = 128;
  parameter int unsigned SMP_W  = 6;
  parameter int unsigned CHIP_W = 8;
  parameter int unsigned TS_W   = 12;

  localparam int unsigned CH_W  = $clog2(N_CH);
  localparam int unsigned HDR_W = CHIP_W + TS_W;
  localparam int unsigned REC_W = CH_W + SMP_W;
  localparam int unsigned END_W = CH_W;
  localparam int unsigned FLD_W = (HDR_W > REC_W) ? HDR_W : REC_W;
  localparam int unsigned LEN_W = $clog2(FLD_W + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_BODY, ST_TAIL} pkt_state_e;

  // A channel is a hit only when strictly above the threshold.
  function automatic logic is_hit(input logic [SMP_W-1:0] v,
                                  input logic [SMP_W-1:0] t);
    return v > t;
  endfunction

  // Left-justify a field of the given width inside the shifter word.
  function automatic logic [FLD_W-1:0] justify(input logic [FLD_W-1:0] f,
                                               input int unsigned w);
    return f << (FLD_W - w);
  endfunction
endpackage

// File: rtl/zs_trig_fifo.sv
module zs_trig_fifo #(
  parameter int unsigned W     = 12,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rd_ptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/zs_hit_finder.sv
module zs_hit_finder
  import zs_pkg::*;
(
  input  logic [N_CH*SMP_W-1:0] samples,
  input  logic [SMP_W-1:0]      thr,
  input  logic [CH_W-1:0]       start,
  output logic                  found,
  output logic [CH_W-1:0]       idx
);
  // The top channel is never reported: its address is the terminator code.
  localparam int unsigned NSCAN = N_CH - 1;

  logic [NSCAN-1:0] hit_vec;

  for (genvar c = 0; c < NSCAN; c++) begin : g_cmp
    assign hit_vec[c] = is_hit(samples[c*SMP_W +: SMP_W], thr) &&
                        (CH_W'(c) >= start);
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NSCAN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        found = 1'b1;
        idx   = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/zs_field_shifter.sv
module zs_field_shifter
  import zs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [FLD_W-1:0] ld_data,
  input  logic [LEN_W-1:0] ld_len,
  output logic             bit_out,
  output logic             active,
  output logic             last
);
  logic [FLD_W-1:0] sh;
  logic [LEN_W-1:0] cnt;

  assign bit_out = sh[FLD_W-1];
  assign active  = (cnt != '0);
  assign last    = (cnt == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (load) begin
      sh  <= ld_data;
      cnt <= ld_len;
    end else if (active) begin
      sh  <= sh << 1;
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/zs_packet_builder.sv
module zs_packet_builder
  import zs_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned QCW       = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trig_in,
  input  logic [N_CH*SMP_W-1:0] samples,
  input  logic [SMP_W-1:0]      thr,
  input  logic [CHIP_W-1:0]     chip_id,
  input  logic [TS_W-1:0]       orbit,
  output logic                  ser_data,
  output logic                  ser_valid,
  output logic                  ovf_err
);
  pkt_state_e       state;
  logic [CH_W-1:0]  scan_ptr;

  // Named internal events, also observed by the checker.
  logic             fifo_pop, fifo_empty, fifo_full;
  logic [QCW-1:0]   fifo_cnt;
  logic [TS_W-1:0]  fifo_ts;
  logic             hit_found;
  logic [CH_W-1:0]  hit_idx;
  logic [SMP_W-1:0] hit_amp;
  logic             sh_bit, sh_active, sh_last;
  logic             body_end, rec_load, tail_load, in_tail, drop_trig;
  logic             ld;
  logic [FLD_W-1:0] ld_data;
  logic [LEN_W-1:0] ld_len;

  zs_trig_fifo #(.W(TS_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (trig_in),
    .pop   (fifo_pop),
    .din   (orbit),
    .dout  (fifo_ts),
    .empty (fifo_empty),
    .full  (fifo_full),
    .count (fifo_cnt)
  );

  zs_hit_finder u_find (
    .samples (samples),
    .thr     (thr),
    .start   (scan_ptr),
    .found   (hit_found),
    .idx     (hit_idx)
  );

  zs_field_shifter u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ld),
    .ld_data (ld_data),
    .ld_len  (ld_len),
    .bit_out (sh_bit),
    .active  (sh_active),
    .last    (sh_last)
  );

  assign hit_amp   = samples[hit_idx*SMP_W +: SMP_W];
  assign fifo_pop  = (state == ST_IDLE) && !fifo_empty;
  assign body_end  = (state == ST_BODY) && sh_last;
  assign rec_load  = body_end && hit_found;
  assign tail_load = body_end && !hit_found;
  assign in_tail   = (state == ST_TAIL);
  assign drop_trig = trig_in && fifo_full && !fifo_pop;
  assign ld        = fifo_pop || body_end;

  always_comb begin
    ld_data = '0;
    ld_len  = '0;
    if (fifo_pop) begin
      ld_data = justify(FLD_W'({chip_id, fifo_ts}), HDR_W);
      ld_len  = LEN_W'(HDR_W);
    end else if (rec_load) begin
      ld_data = justify(FLD_W'({hit_idx, hit_amp}), REC_W);
      ld_len  = LEN_W'(REC_W);
    end else if (tail_load) begin
      ld_data = justify(FLD_W'({END_W{1'b1}}), END_W);
      ld_len  = LEN_W'(END_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      scan_ptr <= '0;
      ovf_err  <= 1'b0;
    end else begin
      if (drop_trig) ovf_err <= 1'b1;
      if (fifo_pop) begin
        state    <= ST_BODY;
        scan_ptr <= '0;
      end else if (rec_load) begin
        scan_ptr <= hit_idx + 1'b1;
      end else if (tail_load) begin
        state <= ST_TAIL;
      end else if (in_tail && sh_last) begin
        state <= ST_IDLE;
      end
    end
  end

  assign ser_valid = sh_active;
  assign ser_data  = sh_active & sh_bit;
endmodule

// File: rtl/zs_packet_checker.sv
module zs_packet_checker
  import zs_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned QCW  = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trig_in,
  input logic            ser_data,
  input logic            ser_valid,
  input logic            ovf_err,
  input logic            fifo_pop,
  input logic            fifo_full,
  input logic [QCW-1:0]  fifo_cnt,
  input logic            rec_load,
  input logic            tail_load,
  input logic            in_tail,
  input logic [CH_W-1:0] hit_idx,
  input logic [CH_W-1:0] scan_ptr
);
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  a_r9_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_err) |-> $past(trig_in && fifo_full && !fifo_pop));

  a_r8_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= QCW'(DEPTH));

  a_r5_no_top_chan: assert property (@(posedge clk) disable iff (!rst_n)
    rec_load |-> (hit_idx != CH_W'(N_CH - 1)));

  a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    rec_load |-> (hit_idx >= scan_ptr));

  a_r6_tail_ones: assert property (@(posedge clk) disable iff (!rst_n)
    tail_load |=> (ser_valid && ser_data));

  a_r7_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !ser_valid);

  a_r7_end_in_tail: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_valid) |-> $past(in_tail));
endmodule

bind zs_packet_builder zs_packet_checker #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig_in   (trig_in),
  .ser_data  (ser_data),
  .ser_valid (ser_valid),
  .ovf_err   (ovf_err),
  .fifo_pop  (fifo_pop),
  .fifo_full (fifo_full),
  .fifo_cnt  (fifo_cnt),
  .rec_load  (rec_load),
  .tail_load (tail_load),
  .in_tail   (in_tail),
  .hit_idx   (hit_idx),
  .scan_ptr  (scan_ptr)
);

// File: tb/zs_packet_builder_test.sv
module zs_packet_builder_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         trig = 1'b0;
  logic [767:0] smp = '0;
  logic [5:0]   thr = '0;
  logic [7:0]   chip = 8'hA5;
  logic [11:0]  orbit = 12'h3F0;
  wire          ser_data, ser_valid, ovf;

  zs_packet_builder uut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig), .samples(smp), .thr(thr),
    .chip_id(chip), .orbit(orbit), .ser_data(ser_data),
    .ser_valid(ser_valid), .ovf_err(ovf)
  );

  always #2 clk = ~clk;
  always @(posedge clk) orbit <= orbit + 12'd1;

  int total = 0, bad = 0, pkts = 0, gap = 1000;
  bit cur[$];
  bit exp_q[$];
  int exp_len[$];
  int gap_q[$];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_pkt();
    int len, mis;
    bit e;
    if (exp_len.size() == 0) begin
      chk(0, "R1", "packet with no trigger", cur.size(), 0);
    end else begin
      len = exp_len.pop_front();
      chk(cur.size() == len, "R6", "packet length", cur.size(), len);
      mis = -1;
      for (int i = 0; i < len; i++) begin
        e = exp_q.pop_front();
        if (mis < 0 && i < cur.size() && cur[i] != e) mis = i;
      end
      chk(mis < 0, "R2 R3 R4 R5", "first wrong bit position", mis, -1);
    end
    cur.delete();
    pkts++;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_valid) begin
        if (cur.size() == 0) gap_q.push_back(gap);
        gap = 0;
        cur.push_back(ser_data);
      end else begin
        gap++;
        if (cur.size() > 0) finish_pkt();
      end
    end
  end

  // Reference packet built from the sample array, threshold and timestamp.
  task automatic expect_pkt(input logic [11:0] ts);
    int n = 0;
    logic [5:0] v;
    for (int b = 7; b >= 0; b--) exp_q.push_back(chip[b]);
    for (int b = 11; b >= 0; b--) exp_q.push_back(ts[b]);
    for (int c = 0; c < 127; c++) begin
      v = smp[c*6 +: 6];
      if (v > thr) begin
        for (int b = 6; b >= 0; b--) exp_q.push_back(c[b]);
        for (int b = 5; b >= 0; b--) exp_q.push_back(v[b]);
        n++;
      end
    end
    for (int b = 0; b < 7; b++) exp_q.push_back(1'b1);
    exp_len.push_back(27 + 13 * n);
  endtask

  // Exactly n of the 128 channels above threshold; the others at or below it.
  task automatic fill(input int n, input int seed, input logic [5:0] t);
    int pos;
    thr = t;
    for (int c = 0; c < 128; c++) begin
      pos = (c * 37 + seed) % 128;
      if (pos < n) smp[c*6 +: 6] = 6'(int'(t) + 1 + c % (63 - int'(t)));
      else         smp[c*6 +: 6] = 6'(c % (int'(t) + 1));
    end
  endtask

  task automatic one_pkt();
    int target = pkts + 1;
    @(negedge clk);
    trig = 1'b1;
    expect_pkt(orbit);
    @(negedge clk);
    trig = 1'b0;
    wait (pkts == target);
    @(negedge clk);
  endtask

  task automatic report();
    if (exp_len.size() != 0) chk(0, "R1", "packets missing", exp_len.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "R1", "watchdog expired", 0, 1);
      report();
    end
  end

  initial begin
    int target;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(ser_valid == 0, "R10", "ser_valid in reset", ser_valid, 0);
    chk(ovf == 0, "R10", "ovf_err in reset", ovf, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ser_valid == 0, "R10", "ser_valid after reset", ser_valid, 0);

    // R1: start latency from an idle block; R6 nominal 5 hits -> 85 + 7 bits
    fill(5, 11, 6'd20);
    @(negedge clk);
    trig = 1'b1;
    expect_pkt(orbit);
    @(negedge clk);
    trig = 1'b0;
    chk(ser_valid == 0, "R1", "valid one cycle after trigger edge", ser_valid, 0);
    @(negedge clk);
    chk(ser_valid == 1, "R1", "valid two cycles after trigger edge", ser_valid, 1);
    wait (pkts == 1);
    chk(exp_len.size() == 0, "R1", "one packet per trigger", exp_len.size(), 0);

    // R3: all samples equal to the threshold give no record
    thr = 6'd63;
    for (int c = 0; c < 128; c++) smp[c*6 +: 6] = 6'd63;
    one_pkt();
    // R5: only channel 127 above threshold -> empty packet
    thr = 6'd10;
    smp = '0;
    smp[127*6 +: 6] = 6'd50;
    one_pkt();
    // R3: threshold zero, samples zero and one
    thr = 6'd0;
    for (int c = 0; c < 128; c++) smp[c*6 +: 6] = 6'(c % 2);
    one_pkt();

    // R3 R4 R6: occupancy sweep
    for (int n = 0; n <= 16; n++) begin
      fill(n, n * 5, 6'(3 + n % 40));
      one_pkt();
    end
    for (int n = 23; n <= 128; n += 7) begin
      fill(n, n, 6'(3 + n % 40));
      one_pkt();
    end
    fill(128, 0, 6'd30);
    one_pkt();

    // R8 R9 R7: burst of 6 triggers while busy; the sixth finds the queue full
    fill(128, 3, 6'd7);
    target = pkts + 5;
    gap_q.delete();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k == 5) chk(ovf == 0, "R9", "ovf_err before queue full", ovf, 0);
      trig = 1'b1;
      if (k < 5) expect_pkt(orbit);
    end
    @(negedge clk);
    trig = 1'b0;
    chk(ovf == 1, "R9", "ovf_err after dropped trigger", ovf, 1);
    wait (pkts == target);
    repeat (40) @(negedge clk);
    chk(pkts == target, "R8", "queued packets served", pkts, target);
    chk(gap_q.size() == 5, "R8", "packets in burst", gap_q.size(), 5);
    for (int i = 1; i < gap_q.size(); i++)
      chk(gap_q[i] == 1, "R7", "idle gap between queued packets", gap_q[i], 1);
    chk(ovf == 1, "R9", "ovf_err sticky", ovf, 1);

    // R10: reset clears the flag; block works afterwards
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ovf == 0, "R10", "ovf_err after second reset", ovf, 0);
    fill(9, 2, 6'd15);
    one_pkt();

    finished = 1;
    report();
  end
endmodule